// File: doc/BRIEF.md
# Four-Way Set-Associative Tag Lookup with LRU Victim Selection

This block holds the tag, valid and data storage of a small cache organised as 256 sets of four ways. Each request address is split into a byte offset, a set index and a tag. The selected set's four stored tags are compared with the request tag at the same time. The block reports a hit, the number of the way that matched, and that way's data word through a four-input selector. All of these outputs are combinational from the address and the stored state.

When the address misses, the block names the way that a fill would replace. An empty way is used before any occupied way is displaced. When all four ways hold lines, the least recently used way is chosen. A fill strobe writes the tag and the fill word into that way and marks it valid. Recency is tracked per set as a two-bit rank for each way. Hits that are flagged as real lookups and fills both update the rank. A flag reports more than one matching way in a set; a correct design never raises it.

Top module: `setassoc_lookup`

## Requirements
- R1: After reset every way of every set is empty: any address misses and the offered victim is way 0.
- R2: The address fields are the byte offset in bits 1:0, the set index in bits 9:2 and the tag in bits 31:10. The offset has no effect on the result.
- R3: When a valid way of the indexed set holds the request tag, `hit` is 1, `hit_way` gives that way's number (0 to 3) and `rd_data` gives that way's stored word.
- R4: When no valid way matches, `hit` is 0 and `rd_data` is 0.
- R5: A clock edge with `fill` high on a missing address stores the tag and `fill_data` into the offered victim way and marks it valid. Afterwards the same address hits with that word.
- R6: While the indexed set has an empty way, the victim is the lowest-numbered empty way.
- R7: When all four ways are valid, the victim is the least recently used way of that set.
- R8: A fill, or a hit with `lookup` high, makes the accessed way the most recent. Ways that were more recent than it move one step older. A hit with `lookup` low leaves the order unchanged.
- R9: A `fill` on an address that already hits is ignored: the stored word and the order are unchanged.
- R10: `multi_hit` is 1 only if two or more ways of the indexed set match. It stays 0 in all operation through this interface.
- R11: Fills and recency updates change only the indexed set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 32 | Request address |
| lookup | input | 1 | Marks a real access; a hit updates recency |
| fill | input | 1 | Write fill_data into the victim way on a miss |
| fill_data | input | 32 | Word to store on a fill |
| hit | output | 1 | A valid way matches the tag |
| hit_way | output | 2 | Number of the matching way |
| rd_data | output | 32 | Data of the matching way, 0 on a miss |
| victim_way | output | 2 | Way a fill would replace |
| multi_hit | output | 1 | More than one way matches (error) |

## Verification
The assertions check several rules on every cycle. At most one way may match. A miss must drive zero data. An empty way must never lose to an occupied one. The recency ranks of the addressed set must stay a permutation. A fill on a miss must hit on the next cycle with the word that was written. Only the bench's scenarios can show the exact replacement order after mixed hits and fills. They also show that an offset change, a lookup with the strobe low, or a fill on a hit leaves the state alone, and that one set's activity does not disturb another.

// File: rtl/setassoc_pkg.sv
// Package: shared constants and the recency-update command used between
// the top level and the recency store.
package setassoc_pkg;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_OFF_W  = 2;
    localparam int DEF_IDX_W  = 8;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_WAY_W  = 2;

    // Recency update requested for the indexed set in the current cycle.
    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_TOUCH = 2'd1,
        UPD_FILL  = 2'd2
    } upd_op_e;
endpackage

// File: rtl/way_compare.sv
// Module: way_compare
// Compares one request tag with every way of a set in parallel.
// It produces the match vector, the OR-ed hit, the encoded way number and
// a flag for more than one match.
// Assumes: WAYS == 2**WAY_W.
module way_compare #(
    parameter int TAG_W = 22,
    parameter int WAY_W = 2,
    localparam int WAYS = 1 << WAY_W
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            req_tag,
    output logic [WAYS-1:0]             match,
    output logic                        any_hit,
    output logic [WAY_W-1:0]            match_way,
    output logic                        many_hit
);
    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign any_hit = |match;

    // Encode the matching way; OR of indices is exact for a one-hot vector.
    always_comb begin
        match_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) match_way = match_way | WAY_W'(w);
    end

    // Count matches to detect a duplicated tag.
    always_comb begin
        int n;
        n = 0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) n = n + 1;
        many_hit = (n > 1);
    end
endmodule

// File: rtl/way_mux.sv
// Module: way_mux
// Selects the data word of the hitting way and drives zero on a miss.
// Assumes: sel is meaningful only when hit is high.
module way_mux #(
    parameter int DATA_W = 32,
    parameter int WAY_W  = 2,
    localparam int WAYS  = 1 << WAY_W
) (
    input  logic [WAYS-1:0][DATA_W-1:0] way_data,
    input  logic                        hit,
    input  logic [WAY_W-1:0]            sel,
    output logic [DATA_W-1:0]           dout
);
    // Four-to-one selection gated by the hit signal.
    always_comb dout = hit ? way_data[sel] : '0;
endmodule

// File: rtl/lru_ranks.sv
// Module: lru_ranks
// Keeps a rank per way for every set: 0 is most recent and WAYS-1 is
// least recent. It picks the victim of the indexed set: the lowest empty
// way if there is one, otherwise the way with the oldest rank.
// Assumes: ranks of a set always form a permutation (set at reset, kept by
// the update rule).
module lru_ranks
    import setassoc_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int WAY_W = 2,
    localparam int WAYS = 1 << WAY_W,
    localparam int SETS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [WAYS-1:0]  set_valid,
    input  upd_op_e          op,
    input  logic [WAY_W-1:0] op_way,
    output logic [WAY_W-1:0] victim
);
    logic [WAYS-1:0][WAY_W-1:0] rank_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] cur;

    assign cur = rank_q[idx];

    // Victim choice: lowest empty way first, otherwise the oldest way.
    always_comb begin
        logic found;
        victim = '0;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++)
            if (!found && !set_valid[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        if (!found)
            for (int w = 0; w < WAYS; w++)
                if (cur[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end

    // Rank update: accessed way becomes 0, more recent ways age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (op != UPD_NONE) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == op_way)
                    rank_q[idx][w] <= '0;
                else if (cur[w] < cur[op_way])
                    rank_q[idx][w] <= cur[w] + 1'b1;
            end
        end
    end

    // Helper: ranks of the indexed set are all distinct.
    logic ranks_distinct;
    always_comb begin
        ranks_distinct = 1'b1;
        for (int a = 0; a < WAYS; a++)
            for (int b = a + 1; b < WAYS; b++)
                if (cur[a] == cur[b]) ranks_distinct = 1'b0;
    end

    // R8: the recency order of the addressed set stays a permutation.
    a_r8_ranks_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        ranks_distinct);

    // R6: an empty way is never passed over for an occupied one.
    a_r6_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&set_valid)) |-> !set_valid[victim]);
endmodule

// File: rtl/setassoc_lookup.sv
// Module: setassoc_lookup (top)
// Tag, valid and data storage for a four-way, 256-set cache, with a
// parallel compare, a way selector and recency-based replacement.
// Lookup outputs are combinational from addr. A fill on a miss writes the
// victim way at the clock edge, and a flagged hit or a fill updates
// recency at the same edge.
// Assumes: synchronous active-low reset clears only valid bits and ranks.
module setassoc_lookup
    import setassoc_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OFF_W  = DEF_OFF_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int WAY_W  = DEF_WAY_W,
    localparam int WAYS  = 1 << WAY_W,
    localparam int SETS  = 1 << IDX_W,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lookup,
    input  logic              fill,
    input  logic [DATA_W-1:0] fill_data,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] rd_data,
    output logic [WAY_W-1:0]  victim_way,
    output logic              multi_hit
);
    logic [WAYS-1:0]              valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
    logic [WAYS-1:0][DATA_W-1:0]  data_q  [SETS];

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] req_tag;
    logic [WAYS-1:0]  match;
    logic             do_fill;
    upd_op_e          op;
    logic [WAY_W-1:0] op_way;

    // Address field split.
    assign idx     = addr[OFF_W +: IDX_W];
    assign req_tag = addr[ADDR_W-1 -: TAG_W];

    way_compare #(.TAG_W(TAG_W), .WAY_W(WAY_W)) u_cmp (
        .way_valid (valid_q[idx]),
        .way_tag   (tag_q[idx]),
        .req_tag   (req_tag),
        .match     (match),
        .any_hit   (hit),
        .match_way (hit_way),
        .many_hit  (multi_hit)
    );

    way_mux #(.DATA_W(DATA_W), .WAY_W(WAY_W)) u_mux (
        .way_data (data_q[idx]),
        .hit      (hit),
        .sel      (hit_way),
        .dout     (rd_data)
    );

    // Decide the recency update: a fill on a miss wins over a touch.
    assign do_fill = fill && !hit;
    always_comb begin
        op     = UPD_NONE;
        op_way = hit_way;
        if (do_fill) begin
            op     = UPD_FILL;
            op_way = victim_way;
        end else if (lookup && hit) begin
            op = UPD_TOUCH;
        end
    end

    lru_ranks #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .set_valid (valid_q[idx]),
        .op        (op),
        .op_way    (op_way),
        .victim    (victim_way)
    );

    // Valid bits: cleared by reset, set by a fill into the victim way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (do_fill) begin
            valid_q[idx][victim_way] <= 1'b1;
        end
    end

    // Tag and data storage written on a fill; not reset.
    always_ff @(posedge clk) begin
        if (do_fill) begin
            tag_q[idx][victim_way]  <= req_tag;
            data_q[idx][victim_way] <= fill_data;
        end
    end

    // R10: at most one way of the indexed set matches.
    a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R4: a miss drives zero data.
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rd_data == '0));

    // R5: a fill on a miss hits on the next cycle with the written word.
    a_r5_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !hit) |=> ((addr != $past(addr)) ||
                            (hit && rd_data == $past(fill_data))));
endmodule

// File: tb/setassoc_lookup_tb.sv
// Bench: reference model of storage and recency, directed corner cases
// followed by seeded random traffic over a few sets and tags.
module setassoc_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        lookup = 1'b0;
    logic        fill = 1'b0;
    logic [31:0] fill_data = '0;
    logic        hit;
    logic [1:0]  hit_way;
    logic [31:0] rd_data;
    logic [1:0]  victim_way;
    logic        multi_hit;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    bit          mvalid [256][4];
    logic [21:0] mtag   [256][4];
    logic [31:0] mdata  [256][4];
    int          mrank  [256][4];

    always #10 clk = ~clk;

    setassoc_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .lookup(lookup), .fill(fill),
        .fill_data(fill_data), .hit(hit), .hit_way(hit_way), .rd_data(rd_data),
        .victim_way(victim_way), .multi_hit(multi_hit)
    );

    function automatic logic [31:0] mk(int t, int i, int o);
        return {t[21:0], i[7:0], o[1:0]};
    endfunction

    task automatic chk(string ctx, string req, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", ctx, req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 4; w++) begin
                mvalid[s][w] = 1'b0;
                mrank[s][w]  = w;
            end
    endtask

    task automatic touch(int s, int way);
        int r;
        r = mrank[s][way];
        for (int w = 0; w < 4; w++)
            if (w == way) mrank[s][w] = 0;
            else if (mrank[s][w] < r) mrank[s][w]++;
    endtask

    // One cycle: drive, check combinational outputs, update the model.
    task automatic step(bit lk, bit fl, logic [31:0] a, logic [31:0] d, string ctx);
        int s, ew, ev, nmatch;
        bit ehit, full;
        logic [21:0] t;
        @(negedge clk);
        lookup = lk; fill = fl; addr = a; fill_data = d;
        #2;
        s = int'(a[9:2]); t = a[31:10];
        ehit = 0; ew = 0; nmatch = 0;
        for (int w = 0; w < 4; w++)
            if (mvalid[s][w] && mtag[s][w] == t) begin
                ehit = 1; ew = w; nmatch++;
            end
        full = 1; ev = 0;
        for (int w = 3; w >= 0; w--)
            if (!mvalid[s][w]) begin full = 0; ev = w; end
        if (full)
            for (int w = 0; w < 4; w++)
                if (mrank[s][w] == 3) ev = w;
        chk(ctx, "R3 hit", {31'd0, hit}, {31'd0, ehit});
        if (ehit) begin
            chk(ctx, "R3 hit_way", {30'd0, hit_way}, ew);
            chk(ctx, "R3 rd_data", rd_data, mdata[s][ew]);
        end else begin
            chk(ctx, "R4 rd_data", rd_data, 32'd0);
            chk(ctx, full ? "R7 victim" : "R6 victim", {30'd0, victim_way}, ev);
        end
        chk(ctx, "R10 multi_hit", {31'd0, multi_hit}, {31'd0, nmatch > 1});
        if (fl && !ehit) begin
            mvalid[s][ev] = 1; mtag[s][ev] = t; mdata[s][ev] = d;
            touch(s, ev);
        end else if (lk && ehit) begin
            touch(s, ew);
        end
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset, victim way 0.
        step(1, 0, mk(3, 5, 0), 0, "R1");
        step(1, 0, mk(0, 255, 3), 0, "R1");
        // R5/R6: four fills fill ways 0..3 in order.
        for (int k = 0; k < 4; k++)
            step(0, 1, mk(10 + k, 5, 0), 32'hA000 + k, "R5");
        for (int k = 0; k < 4; k++)
            step(0, 0, mk(10 + k, 5, 0), 0, "R5");
        // R2: offset bits do not change the result.
        step(1, 0, mk(12, 5, 3), 0, "R2");
        step(1, 0, mk(10, 5, 1), 0, "R2");
        // R8: a hit with lookup low must not refresh way 1.
        step(0, 0, mk(11, 5, 0), 0, "R8");
        // R7: victim is now the oldest way (way 1); fill it.
        step(0, 1, mk(20, 5, 0), 32'hBEEF, "R7");
        step(1, 0, mk(20, 5, 0), 0, "R7");
        // R9: fill on a hitting address is ignored.
        step(0, 1, mk(12, 5, 0), 32'hDEAD, "R9");
        step(0, 0, mk(12, 5, 2), 0, "R9");
        step(0, 0, mk(99, 5, 0), 0, "R9");
        // R11: activity in set 6 leaves set 5 intact.
        step(1, 1, mk(10, 6, 0), 32'h6666, "R11");
        step(0, 0, mk(10, 5, 0), 0, "R11");
        step(0, 0, mk(99, 5, 0), 0, "R11");

        for (int n = 0; n < 4000; n++) begin
            int sel, i;
            sel = int'($urandom_range(3));
            i = (sel == 0) ? 5 : (sel == 1) ? 6 : (sel == 2) ? 200 : 255;
            step(1'($urandom_range(1)), ($urandom_range(9) < 3),
                 mk(int'($urandom_range(7)), i, int'($urandom_range(3))),
                 $urandom, "RND");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule